// File: doc/BRIEF.md
# Joystick Axis Timing Controller

This block measures the positions of up to four joystick axes by timing how long each axis's external one-shot stays high. A measurement is started by a write to the axis value port, or by a write to the legacy-compatible trigger port. At the start, every enabled axis counter clears, and each counter then advances at a selectable prescaled rate for as long as its comparator input stays high. When every enabled axis has stopped, the block sets a ready flag, copies the counts into a readback latch and, if interrupts are enabled, raises a level interrupt.

Software selects one axis at a time for readback through a two-bit field, and it reads a 16-bit count from the axis value port. A continuous mode re-arms the measurement a fixed number of base clocks after each completion. In this mode the latch keeps taking fresh counts. Clearing continuous mode freezes the latch, so software can read the counts as one consistent set. The legacy port reads back the raw button and comparator levels.

Top module: `joy_axis_ctrl`

## Requirements
- R1: A write of any data to the axis value port (address 2) starts a measurement. Every enabled axis counter (axes configuration bits 3:0, bit i for axis i) clears to zero. A disabled axis keeps its previous count.
- R2: At the base rate (hardware configuration bits 2:1 = 00), a counter advances once per clock while its comparator input is high. A comparator held high for K clock edges after the start edge gives a count of K.
- R3: Hardware configuration bits 2:1 scale the count rate. The code 10 gives one half of the base rate, 01 gives one twentieth and 11 gives one two-hundredth. For a high time of K clocks the count is K divided by the divisor, rounded down.
- R4: A count that reaches 0xFFFF stops there, and the axis is treated as finished.
- R5: Axes configuration bit 7 (the ready flag) reads 1 once all enabled axes have stopped. A start clears it. Bits 6:0 read back the last written configuration value.
- R6: Axes configuration bits 5:4 select which latched count the axis value port returns: 00 selects axis 0, 01 axis 1, 10 axis 2 and 11 axis 3.
- R7: A write to the legacy port (address 0) starts a measurement only when at least one axis enable is set and the interrupt enable (hardware configuration bit 0) is set. Otherwise the write has no effect.
- R8: The irq output is high while ready is set and the interrupt enable is set. A read of the axis value port clears it, and a new start also clears it.
- R9: With axes configuration bit 6 set, the latch takes the counts at each completion, and a new measurement starts RESTART_GAP clocks after ready is set. If bit 6 is clear when a self-started measurement completes, the latch keeps its old values.
- R10: The hardware configuration register (address 4) reads back bits 3:0 as written, and bits 7:4 always read as zero.
- R11: A read of the legacy port returns the button inputs in bits 7:4 and the comparator inputs in bits 3:0.
- R12: After reset, both configuration registers read zero, all latched counts read zero, ready is clear and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; also the count reference |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 3 | Register address: 0 legacy, 1 axes config, 2 axis value, 4 hardware config |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| cmp_in | input | 4 | Comparator inputs, high while the axis one-shot runs |
| btn_in | input | 4 | Button inputs, passed to the legacy read |
| irq | output | 1 | Measurement-ready interrupt, a level |

## Verification
A corrupted counter or prescaler state shows up as a wrong count on the axis value port as soon as the measurement completes. The error is off by a predictable amount: a prescaler phase fault shifts the result by one, and a wrong divisor scales it. A stuck running flag or a missed completion leaves the ready bit low and irq quiet for good, and this is visible a few cycles after every comparator has fallen. A latch that updates when it should be frozen replaces the known previous count on the very next read, so each scenario reads back a value that it set up beforehand.

// File: rtl/joy_pkg.sv
package joy_pkg;
    localparam int NUM_AXES = 4;

    localparam logic [2:0] ADDR_LEGACY = 3'd0;
    localparam logic [2:0] ADDR_AXCFG  = 3'd1;
    localparam logic [2:0] ADDR_VALUE  = 3'd2;
    localparam logic [2:0] ADDR_HWCFG  = 3'd4;

    // field positions inside the axes configuration register
    localparam int AXCFG_SEL_LO = 4;
    localparam int AXCFG_CONT   = 6;
    // field positions inside the hardware configuration register
    localparam int HWCFG_IRQ_EN = 0;
    localparam int HWCFG_RATE_LO = 1;

    typedef enum logic [1:0] {
        RATE_FULL  = 2'b00,
        RATE_SLOW  = 2'b01,
        RATE_HALF  = 2'b10,
        RATE_SLOW2 = 2'b11
    } rate_e;
endpackage

// File: rtl/joy_prescale.sv
module joy_prescale #(
    parameter int DIV_HALF      = 2,
    parameter int DIV_TWENTIETH = 20,
    parameter int DIV_SLOW      = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] rate,
    output logic       tick
);
    import joy_pkg::*;

    localparam int PW = $clog2(DIV_SLOW + 1);

    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] last;

    always_comb begin
        case (rate_e'(rate))
            RATE_HALF:  last = PW'(DIV_HALF - 1);
            RATE_SLOW:  last = PW'(DIV_TWENTIETH - 1);
            RATE_SLOW2: last = PW'(DIV_SLOW - 1);
            default:    last = '0;
        endcase
        tick  = !restart && (cnt_q >= last);
        cnt_d = (restart || cnt_q >= last) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: with a divided rate, two ticks never come back to back
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rate != 2'b00) |=> (!tick || rate == 2'b00));
endmodule

// File: rtl/joy_axis_counter.sv
module joy_axis_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             enable,
    input  logic             tick,
    input  logic             cmp,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             run_d, run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (start) begin
            run_d = enable;
            if (enable) cnt_d = '0;
        end else if (run_q) begin
            if (!cmp || cnt_q == CNT_MAX) run_d = 1'b0;
            else if (tick)                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign count   = cnt_q;
    assign running = run_q;

    // R1: an enabled start clears the count and arms the axis
    p_clear_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && enable) |=> (cnt_q == '0 && run_q));
    // R4: a saturated count halts and holds
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start && cnt_q == CNT_MAX) |=> (!run_q && cnt_q == CNT_MAX));
endmodule

// File: rtl/joy_axis_ctrl.sv
module joy_axis_ctrl #(
    parameter int CNT_W         = 16,
    parameter int RESTART_GAP   = 16,
    parameter int DIV_HALF      = 2,
    parameter int DIV_TWENTIETH = 20,
    parameter int DIV_SLOW      = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [3:0]  cmp_in,
    input  logic [3:0]  btn_in,
    output logic        irq
);
    import joy_pkg::*;

    localparam int GAP_W = $clog2(RESTART_GAP);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(RESTART_GAP - 1);

    typedef struct packed {
        logic [6:0]                      cfg;
        logic [3:0]                      hw;
        logic                            ready;
        logic                            meas;
        logic                            ack;
        logic                            sw;
        logic [GAP_W-1:0]                gap;
        logic [NUM_AXES-1:0][CNT_W-1:0]  lat;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_AXES-1:0][CNT_W-1:0] cnt;
    logic [NUM_AXES-1:0]            run;
    logic start, start_sw, start_leg, start_auto, tick;
    logic unused_bits;

    assign unused_bits = bus_wdata[7];

    joy_prescale #(
        .DIV_HALF(DIV_HALF), .DIV_TWENTIETH(DIV_TWENTIETH), .DIV_SLOW(DIV_SLOW)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(start),
        .rate(s_q.hw[HWCFG_RATE_LO +: 2]), .tick(tick)
    );

    for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
        joy_axis_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .start(start), .enable(s_q.cfg[i]),
            .tick(tick), .cmp(cmp_in[i]), .count(cnt[i]), .running(run[i])
        );
    end

    always_comb begin
        s_d        = s_q;
        start_sw   = bus_wr && bus_addr == ADDR_VALUE;
        start_leg  = bus_wr && bus_addr == ADDR_LEGACY
                     && (|s_q.cfg[NUM_AXES-1:0]) && s_q.hw[HWCFG_IRQ_EN];
        start_auto = s_q.ready && s_q.cfg[AXCFG_CONT] && !s_q.meas && s_q.gap == GAP_LAST;
        start      = start_sw || start_leg || start_auto;

        if (bus_wr && bus_addr == ADDR_AXCFG) s_d.cfg = bus_wdata[6:0];
        if (bus_wr && bus_addr == ADDR_HWCFG) s_d.hw  = bus_wdata[3:0];
        if (bus_rd && bus_addr == ADDR_VALUE) s_d.ack = 1'b1;

        s_d.gap = (s_q.ready && s_q.cfg[AXCFG_CONT] && !s_q.meas) ? s_q.gap + 1'b1 : '0;

        if (start) begin
            s_d.ready = 1'b0;
            s_d.meas  = 1'b1;
            s_d.ack   = 1'b0;
            s_d.sw    = start_sw || start_leg;
            s_d.gap   = '0;
        end else if (s_q.meas && run == '0) begin
            s_d.ready = 1'b1;
            s_d.meas  = 1'b0;
            if (s_q.cfg[AXCFG_CONT] || s_q.sw) s_d.lat = cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_LEGACY: bus_rdata = {8'h00, btn_in, cmp_in};
            ADDR_AXCFG:  bus_rdata = {8'h00, s_q.ready, s_q.cfg};
            ADDR_VALUE:  bus_rdata = 16'(s_q.lat[s_q.cfg[AXCFG_SEL_LO +: 2]]);
            ADDR_HWCFG:  bus_rdata = {12'h000, s_q.hw};
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = s_q.ready && s_q.hw[HWCFG_IRQ_EN] && !s_q.ack;

    // R5: ready is only reported once no enabled axis is still counting
    p_ready_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ready |-> (run == '0));
    // R8: any start drops the interrupt on the next cycle
    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !irq);
    // R8: a read of the value port silences the interrupt
    p_irq_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_VALUE && !start) |=> !irq);
    // R9: with continuous mode off and no software start, the latch is frozen
    p_latch_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.cfg[AXCFG_CONT] && !s_q.sw && !start_sw && !start_leg) |=> $stable(s_q.lat));
endmodule

// File: tb/joy_axis_ctrl_test.sv
`timescale 1ns/100ps
module joy_axis_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cmp_in = '0, btn_in = '0;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    joy_axis_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_in(cmp_in), .btn_in(btn_in), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        rd(3'd1, v); check("R12 axes cfg", v, 0);
        rd(3'd4, v); check("R12 hw cfg", v, 0);
        rd(3'd2, v); check("R12 value", v, 0);
        check("R12 irq", irq, 0);
    endtask

    task automatic t_base_count;
        int v;
        wr(3'd1, 8'h01); wr(3'd4, 8'h00);
        cmp_in = 4'hF;
        wr(3'd2, 8'h5A);
        wait_edges(37);
        cmp_in = 4'h0;
        wait_edges(4);
        rd(3'd2, v); check("R2 base count", v, 37);
        rd(3'd1, v); check("R5 ready and cfg", v, 8'h81);
    endtask

    task automatic t_prescale;
        int v;
        logic [1:0] codes [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
        int divs [4] = '{1, 2, 20, 200};
        for (int k = 0; k < 4; k++) begin
            wr(3'd4, {5'b0, codes[k], 1'b0});
            cmp_in = 4'h1;
            wr(3'd2, 8'h00);
            wait_edges(450);
            cmp_in = 4'h0;
            wait_edges(4);
            rd(3'd2, v); check("R3 prescaled count", v, 450 / divs[k]);
        end
        wr(3'd4, 8'h00);
    endtask

    task automatic t_select;
        int v;
        int kv [4] = '{5, 9, 13, 17};
        wr(3'd1, 8'h0F);
        cmp_in = 4'hF;
        wr(3'd2, 8'h00);
        for (int j = 1; j <= 17; j++) begin
            @(posedge clk); @(negedge clk);
            for (int i = 0; i < 4; i++) if (j == kv[i]) cmp_in[i] = 1'b0;
        end
        wait_edges(4);
        for (int i = 0; i < 4; i++) begin
            wr(3'd1, 8'h0F | 8'(i << 4));
            rd(3'd2, v); check("R6 selected axis", v, kv[i]);
        end
        // only axis 0 enabled: axis 1 must keep its count (R1)
        wr(3'd1, 8'h01);
        cmp_in = 4'hF;
        wr(3'd2, 8'h00);
        wait_edges(3);
        cmp_in = 4'h0;
        wait_edges(4);
        rd(3'd2, v); check("R1 enabled axis restarted", v, 3);
        wr(3'd1, 8'h11);
        rd(3'd2, v); check("R1 disabled axis kept", v, 9);
        cmp_in = 4'hF;
        wr(3'd2, 8'h00);
        rd(3'd1, v); check("R1 start clears ready", v, 8'h11);
        cmp_in = 4'h0;
        wait_edges(4);
    endtask

    task automatic t_irq_legacy;
        int v;
        wr(3'd1, 8'h01); wr(3'd4, 8'h01);
        cmp_in = 4'h0;
        wr(3'd0, 8'h00);
        check("R8 irq low after start", irq, 0);
        wait_edges(3);
        check("R8 irq high when ready", irq, 1);
        rd(3'd2, v);
        check("R8 irq cleared by value read", irq, 0);
        wr(3'd0, 8'hFF);
        wait_edges(3);
        check("R7 legacy write starts", irq, 1);
        // interrupts disabled: legacy write ignored
        wr(3'd4, 8'h00);
        cmp_in = 4'h1;
        wr(3'd0, 8'h00);
        wait_edges(3);
        rd(3'd1, v); check("R7 ignored without irq enable", v, 8'h81);
        // no axis enabled: legacy write ignored
        wr(3'd4, 8'h01); wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        wait_edges(3);
        rd(3'd1, v); check("R7 ignored without axes", v, 8'h80);
        check("R8 irq with ready and enable", irq, 1);
        cmp_in = 4'h0;
        wr(3'd4, 8'h00);
    endtask

    task automatic t_hw_legacy_read;
        int v;
        wr(3'd4, 8'hFE);
        rd(3'd4, v); check("R10 hw cfg upper zero", v, 8'h0E);
        wr(3'd4, 8'h00);
        btn_in = 4'hA; cmp_in = 4'h5;
        rd(3'd0, v); check("R11 legacy read", v, 8'hA5);
        btn_in = 4'h0; cmp_in = 4'h0;
        wait_edges(2);
    endtask

    task automatic t_continuous;
        int v;
        wr(3'd1, 8'h41);
        cmp_in = 4'h1;
        wr(3'd2, 8'h00);
        wait_edges(30);
        cmp_in = 4'h0;
        wait_edges(9);
        rd(3'd1, v); check("R9 ready in continuous mode", v, 8'hC1);
        rd(3'd2, v); check("R9 latched count", v, 30);
        cmp_in = 4'h1;
        wait_edges(30);
        rd(3'd1, v); check("R9 self restart", v, 8'h41);
        wr(3'd1, 8'h01);
        cmp_in = 4'h0;
        wait_edges(6);
        rd(3'd1, v); check("R9 finished after freeze", v, 8'h81);
        rd(3'd2, v); check("R9 latch frozen", v, 30);
    endtask

    task automatic t_saturate;
        int v;
        wr(3'd1, 8'h01); wr(3'd4, 8'h00);
        cmp_in = 4'h1;
        wr(3'd2, 8'h00);
        wait_edges(65545);
        rd(3'd1, v); check("R4 ready on saturation", v, 8'h81);
        rd(3'd2, v); check("R4 saturated count", v, 16'hFFFF);
        cmp_in = 4'h0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_base_count();
        t_prescale();
        t_select();
        t_irq_legacy();
        t_hw_legacy_read();
        t_continuous();
        t_saturate();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule